// File: doc/BRIEF.md
# Arithmetic Right Shifter with Carry Flag

This block is a 32-bit sign-preserving right-shift unit for an integer execution pipeline. It accepts a source word and a shift-control word. Bit numbering is big-endian: bit 0 is the most significant bit and bit 31 is the least significant. The source moves toward bit 31. Bits that pass bit 31 are discarded, and the vacated positions on the left take copies of the source sign bit.

A carry flag is also produced. It is set only when a negative source loses at least one 1 bit. An add-carry-to-zero step that follows can use this flag to round a signed division by a power of two toward zero. When the record input is high, a 4-bit condition field is also written. It holds the signed comparison of the result with zero, plus a copy of the summary-overflow input.

Operands enter with a valid strobe. All outputs are registered, and valid-out follows valid-in by one cycle.

Top module: `sra_carry_unit`

## Requirements
- R1: The shift count is bits 27–31 of the shift-control word, which are the five least significant bits. When bit 26 (value 0x20) is clear, the result equals the source shifted right arithmetically by that count, with vacated bits filled with the source sign bit.
- R2: When bit 26 of the shift-control word is set, every result bit equals the source sign bit, whatever the count field holds.
- R3: Carry is 1 only when the source is negative and at least one discarded bit is 1. In every other case carry is 0. In the full-fill case, all 32 source bits count as discarded.
- R4: A count of zero with bit 26 clear gives carry 0 and a result equal to the source, including for a negative source.
- R5: Bits 0–25 of the shift-control word (mask 0xFFFFFFC0) have no effect on the result or the carry.
- R6: When the record input is 1, the condition field is written from the result as {LT,GT,EQ,SO} in bits [3:0], with LT at bit 3. LT, GT and EQ come from a signed comparison of the result with zero, and SO copies the summary-overflow input. The condition-update strobe is asserted with valid-out.
- R7: When the record input is 0, the condition field keeps its previous value and the update strobe is 0.
- R8: Valid-out, result, carry, condition field and update strobe are registered, one cycle after valid-in. A cycle without valid-in gives valid-out 0 and leaves result, carry and condition unchanged.
- R9: A synchronous active-high reset clears valid-out, carry, the condition field and the update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src_word | input | 32 | Value to shift |
| amt_word | input | 32 | Shift-control word; only its six low bits are used |
| rec_en | input | 1 | Record: update the condition field |
| so_in | input | 1 | Summary-overflow bit to copy |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Shifted result |
| carry | output | 1 | Carry flag |
| cond | output | 4 | Condition field {LT,GT,EQ,SO} |
| cond_wr | output | 1 | Condition field updated this cycle |

## Verification
A wrong count decode or fill-select state shows up one cycle later as a wrong result word on the first operand that uses the affected count. Carry errors are subtle because they depend on both the sign and the discarded bits. For that reason the stimulus concentrates on negative sources with low-order ones and zeros. If the condition register is loaded when record is 0, the error shows up on the very next output cycle as a changed condition field with the strobe low. Each output is compared one cycle after the operands are driven.

// File: rtl/sra_carry_pkg.sv
package sra_carry_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned CNT_W = $clog2(XLEN);

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  // Arithmetic right shift by cnt.
  function automatic logic [XLEN-1:0] asr(input logic [XLEN-1:0] v,
                                          input logic [CNT_W-1:0] cnt);
    return $unsigned($signed(v) >>> cnt);
  endfunction

  // Mask that selects the low cnt bits, which are the ones discarded.
  function automatic logic [XLEN-1:0] lost_mask(input logic [CNT_W-1:0] cnt);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i < int'(cnt));
    return m;
  endfunction

  // Signed comparison of v with zero, plus the copied summary-overflow bit.
  function automatic cond_t compare0(input logic [XLEN-1:0] v, input logic so);
    cond_t c;
    c.lt = v[XLEN-1];
    c.eq = (v == '0);
    c.gt = !v[XLEN-1] && (v != '0);
    c.so = so;
    return c;
  endfunction
endpackage

// File: rtl/sra_shift_core.sv
module sra_shift_core
  import sra_carry_pkg::*;
(
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] amt,
  output logic [XLEN-1:0] shifted,
  output logic            lost_one,
  output logic            full_fill
);
  logic [CNT_W-1:0] cnt;
  logic [XLEN-1:0]  sign_word;

  assign cnt       = amt[CNT_W-1:0];
  assign full_fill = amt[CNT_W];
  assign sign_word = {XLEN{src[XLEN-1]}};

  always_comb begin
    if (full_fill) begin
      shifted  = sign_word;
      lost_one = |src;
    end else begin
      shifted  = asr(src, cnt);
      lost_one = |(src & lost_mask(cnt));
    end
  end

  // R2: with full fill, the result is all copies of the sign bit
  always_comb a_r2_full_fill: assert (!full_fill || shifted == sign_word);
  // R4: a zero count leaves the source unchanged
  always_comb a_r4_zero_count:
    assert (full_fill || cnt != '0 || (shifted == src && !lost_one));
endmodule

// File: rtl/sra_cond_gen.sv
module sra_cond_gen
  import sra_carry_pkg::*;
(
  input  logic [XLEN-1:0] value,
  input  logic            so,
  output cond_t           cond
);
  assign cond = compare0(value, so);
  // R6: exactly one of LT, GT and EQ is set
  always_comb a_r6_one_relation: assert ($onehot({cond.lt, cond.gt, cond.eq}));
endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit
  import sra_carry_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] src_word,
  input  logic [31:0] amt_word,
  input  logic        rec_en,
  input  logic        so_in,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        carry,
  output logic [3:0]  cond,
  output logic        cond_wr
);
  logic [XLEN-1:0] shifted;
  logic            lost_one, full_fill, carry_next, cond_load;
  cond_t           cond_next, cond_q;

  sra_shift_core u_core (
    .src(src_word), .amt(amt_word), .shifted(shifted),
    .lost_one(lost_one), .full_fill(full_fill)
  );

  sra_cond_gen u_cond (.value(shifted), .so(so_in), .cond(cond_next));

  assign carry_next = src_word[XLEN-1] & lost_one;
  assign cond_load  = in_valid & rec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      carry     <= 1'b0;
      cond_q    <= '0;
      cond_wr   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      cond_wr   <= cond_load;
      if (in_valid) begin
        result <= shifted;
        carry  <= carry_next;
      end
      if (cond_load) cond_q <= cond_next;
    end
  end

  assign cond = cond_q;

  // R3: carry is never set from a non-negative source
  always_comb a_r3_carry_sign: assert (!carry_next || src_word[XLEN-1]);
  // R7: without record, the condition field is held
  a_r7_cond_hold: assert property (@(posedge clk) disable iff (rst)
    !cond_load |=> $stable(cond));
  // R8: valid-out follows valid-in by one cycle
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R6: the update strobe appears only with valid-out
  a_r6_strobe: assert property (@(posedge clk) disable iff (rst)
    cond_wr |-> out_valid);
  // R9: after reset, valid-out and carry are clear
  a_r9_reset: assert property (@(posedge clk) rst |=> (!out_valid && !carry && cond == 4'd0));
endmodule

// File: tb/sra_carry_unit_test.sv
module sra_carry_unit_test;
  logic clk = 0, rst = 1, in_valid = 0, rec_en = 0, so_in = 0;
  logic [31:0] src_word = 0, amt_word = 0;
  logic out_valid, carry, cond_wr;
  logic [31:0] result;
  logic [3:0] cond;
  int checks = 0, errors = 0;
  logic [3:0] exp_cond = 0;

  sra_carry_unit uut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: expired, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Reference result: computed bit by bit, a different method from the RTL.
  function automatic logic [31:0] ref_res(input logic [31:0] s, input logic [31:0] a);
    logic [31:0] r;
    int n = a[4:0];
    if (a[5]) return {32{s[31]}};
    for (int i = 0; i < 32; i++) r[i] = (i + n > 31) ? s[31] : s[i+n];
    return r;
  endfunction

  // Reference carry: the source value minus the shifted-back result differs from zero.
  function automatic logic ref_cy(input logic [31:0] s, input logic [31:0] a);
    logic [31:0] r = ref_res(s, a);
    int n = a[5] ? 32 : a[4:0];
    logic [63:0] back = {{32{r[31]}}, r} << n;
    return s[31] && (back[31:0] != s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] a,
                     input logic rec, input logic so, input string tag);
    logic [3:0] c;
    @(negedge clk);
    in_valid = 1; src_word = s; amt_word = a; rec_en = rec; so_in = so;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " R1 R2 R5 result"}, result, ref_res(s, a));
    chk({tag, " R3 carry"}, {31'd0, carry}, {31'd0, ref_cy(s, a)});
    if (rec) begin
      c = {$signed(ref_res(s, a)) < 0, $signed(ref_res(s, a)) > 0,
           ref_res(s, a) == 0, so};
      exp_cond = c;
      chk({tag, " R6 cond"}, {28'd0, cond}, {28'd0, exp_cond});
      chk({tag, " R6 strobe"}, {31'd0, cond_wr}, 32'd1);
    end else begin
      chk({tag, " R7 cond held"}, {28'd0, cond}, {28'd0, exp_cond});
      chk({tag, " R7 strobe"}, {31'd0, cond_wr}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] keep_r;
    logic keep_c;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 valid", {31'd0, out_valid}, 0);
    chk("R9 carry", {31'd0, carry}, 0);
    chk("R9 cond", {28'd0, cond}, 0);
    chk("R9 strobe", {31'd0, cond_wr}, 0);
    run(32'h8000_0001, 32'd0, 1, 0, "R4 neg count0");
    run(32'h8000_0000, 32'd31, 1, 1, "min count31");
    run(32'hFFFF_FFFF, 32'd31, 1, 0, "minus1 count31");
    run(32'hFFFF_FFFF, 32'd1, 0, 0, "minus1 count1");
    run(32'h8000_0000, 32'h20, 1, 0, "R2 min fill");
    run(32'h1234_5678, 32'h3F, 1, 1, "R2 pos fill");
    run(32'hFFFF_FF00, 32'd8, 1, 0, "R3 zeros lost");
    run(32'hFFFF_FF00, 32'd9, 1, 0, "R3 one lost");
    run(32'h7FFF_FFFF, 32'd4, 0, 1, "R3 pos lost");
    run(32'h0000_0000, 32'd5, 1, 0, "zero eq");
    run(32'hF000_000F, 32'hFFFF_FFC3, 1, 1, "R5 upper bits");
    run(32'h0000_000F, 32'd0, 1, 0, "R4 pos count0");
    // R8: an idle cycle leaves the outputs unchanged
    keep_r = result; keep_c = carry;
    @(negedge clk);
    chk("R8 idle valid", {31'd0, out_valid}, 0);
    chk("R8 idle result", result, keep_r);
    chk("R8 idle carry", {31'd0, carry}, {31'd0, keep_c});
    for (int i = 0; i < 300; i++) begin
      logic [31:0] s = $urandom;
      logic [31:0] a = $urandom;
      if (i % 3 == 0) s[31] = 1'b1;
      if (i % 4 != 0) a[5] = 1'b0;
      run(s, a, 1'($urandom), 1'($urandom), "random");
    end
    // R9: reset clears the condition field and carry
    run(32'h8000_0003, 32'd1, 1, 1, "pre-reset");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R9 re carry", {31'd0, carry}, 0);
    chk("R9 re cond", {28'd0, cond}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule